// File: doc/BRIEF.md
# PWM duty command capture

This block turns an external speed input, a pulse-width-modulated logic signal that is already synchronised to the system clock, into a 9-bit amplitude command for a sinusoidal three-phase drive. It measures the duty cycle over each full input period and quantises it to a code from 0 to 511. It then smooths that code through a first-order low-pass response with a configurable time constant. The default is 80 ms.

A 2-bit setting picks a minimum operating amplitude. Any request between the standby cutoff and that floor is raised to the floor. A duty below about 1.5% puts the block in standby: the command is forced to zero and the filter restarts from zero. If the input stays low long enough and sleep is allowed, the block enters sleep. A rising input wakes it, and the wake acts as a fresh start. A period timeout treats an input that never toggles as 0% or 100% duty, depending on its level.

Top module: `pwmcap_top`

## Requirements
- R1: Each duty sample spans one full input period, measured from rising edge to rising edge. Its code is floor(H*512/P), where H is the number of high clock cycles and P is the number of cycles in the period, and a result of 512 becomes 511. The first rising edge after reset, wake or a timeout only starts a period and produces no sample.
- R2: The filter moves toward its target once every TICK clocks, where TICK = (CLK_HZ/1e6 * TAU_US) >> FILT_SHIFT. Its internal value carries FILT_SHIFT fraction bits. Each move is the gap shifted right by FILT_SHIFT, and is at least one fraction LSB. The output never passes the target and ends exactly on it.
- R3: The floor is chosen by min_duty_sel: 0 gives no floor, 1 gives code 26 (5%), 2 gives code 51 (10%) and 3 gives code 67 (13%).
- R4: Outside standby, amp_cmd equals the larger of the filter output and the floor. A change of min_duty_sel takes effect on amp_cmd at the next clock edge.
- R5: A sample code below 8 (about 1.5%) sets standby. While standby is set, amp_cmd is 0 and the filter is held at zero. A later sample of 8 or more clears standby.
- R6: sleep is set only when sleep_en is 1 and pwm_in has been low for SLEEP_US microseconds. Sleep always comes with standby. With sleep_en at 0, a low input never sets sleep.
- R7: A high pwm_in clears sleep at the next clock edge. Standby then holds until a complete new period has been measured.
- R8: If no rising edge arrives within 2*CLK_HZ/MIN_PWM_HZ clocks, a forced sample is taken: code 511 if pwm_in is high and code 0 if it is low.
- R9: After reset, amp_cmd is 0, standby is 1 and sleep is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Synchronised speed input |
| min_duty_sel | input | 2 | Minimum amplitude floor select |
| sleep_en | input | 1 | Allows entry into sleep |
| amp_cmd | output | 9 | Filtered, clamped amplitude command |
| standby | output | 1 | Drive disabled because the duty is too low |
| sleep | output | 1 | Low-power state after a long low input |

## Verification
Two things decide amp_cmd in the same cycle: the floor clamp and the filter ramp. When the floor select changes while the filter is partway through a ramp or already settled, the clamp and the filtered value meet at the same register. The bench provokes this by stepping min_duty_sel through all four values while the filter sits on code 20, and by ramping up from standby toward 300. Each time it expects amp_cmd to be exactly the larger of the computed floor and the settled or bounded filter value. Sleep entry and standby entry also land on one clock edge. The bench judges that at the ports by reading the sleep, standby and zero-amplitude outputs just before and just after the low-time limit.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
  localparam int CODE_W = 9;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  typedef logic [CODE_W-1:0] code_t;

  // Standby cutoff: 1.5 % of full scale, rounded up to a whole code.
  localparam int STBY_CODE = (15 * (1 << CODE_W) + 999) / 1000;

  // Floor code for the 2-bit selection, percent rounded to nearest code.
  function automatic code_t floor_code(input logic [1:0] sel);
    int pct;
    case (sel)
      2'd1:    pct = 5;
      2'd2:    pct = 10;
      2'd3:    pct = 13;
      default: pct = 0;
    endcase
    return code_t'((pct * (1 << CODE_W) + 50) / 100);
  endfunction
endpackage

// File: rtl/pwmcap_meas.sv
module pwmcap_meas #(
  parameter int TIMEOUT = 6666,
  parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             pwm_in,
  output logic             div_go,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] per_o,
  output logic             frc_v,
  output logic             frc_hi
);
  logic             pwm_d;
  logic             armed;
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] hi_cnt;
  logic             rise;

  assign rise = pwm_in & ~pwm_d;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pwm_d   <= 1'b0;
      armed   <= 1'b0;
      per_cnt <= '0;
      hi_cnt  <= '0;
      div_go  <= 1'b0;
      hi_o    <= '0;
      per_o   <= '0;
      frc_v   <= 1'b0;
      frc_hi  <= 1'b0;
    end else begin
      pwm_d  <= pwm_in;
      div_go <= 1'b0;
      frc_v  <= 1'b0;
      if (rise) begin
        if (armed) begin
          div_go <= 1'b1;
          hi_o   <= hi_cnt;
          per_o  <= per_cnt;
        end
        armed   <= 1'b1;
        per_cnt <= CNT_W'(1);
        hi_cnt  <= CNT_W'(1);
      end else if (per_cnt >= CNT_W'(TIMEOUT)) begin
        frc_v   <= 1'b1;
        frc_hi  <= pwm_in;
        armed   <= 1'b0;
        per_cnt <= CNT_W'(1);
        hi_cnt  <= {{(CNT_W-1){1'b0}}, pwm_in};
      end else begin
        per_cnt <= per_cnt + CNT_W'(1);
        if (pwm_in) hi_cnt <= hi_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwmcap_div.sv
module pwmcap_div
  import pwmcap_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             go,
  input  logic [CNT_W-1:0] num,
  input  logic [CNT_W-1:0] den,
  output logic             done,
  output code_t            q
);
  localparam int STEPS = CODE_W + 1;
  localparam int SC_W  = $clog2(STEPS + 1);

  logic [CNT_W:0]   rem;
  logic [CNT_W:0]   dif;
  logic [CNT_W-1:0] den_q;
  logic [STEPS-1:0] quo;
  logic [SC_W-1:0]  cnt;
  logic             busy;
  logic             ge;

  always_comb begin
    ge  = rem >= {1'b0, den_q};
    dif = ge ? (rem - {1'b0, den_q}) : rem;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem   <= '0;
      den_q <= '0;
      quo   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        rem   <= {1'b0, num};
        den_q <= den;
        quo   <= '0;
        cnt   <= SC_W'(STEPS);
        busy  <= 1'b1;
      end else if (busy) begin
        quo <= {quo[STEPS-2:0], ge};
        rem <= dif << 1;
        cnt <= cnt - SC_W'(1);
        if (cnt == SC_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign q = quo[STEPS-1] ? code_t'(CODE_MAX) : quo[CODE_W-1:0];
endmodule

// File: rtl/pwmcap_lpf.sv
module pwmcap_lpf
  import pwmcap_pkg::*;
#(
  parameter int SHIFT = 8,
  parameter int TICK  = 15625
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  code_t tgt,
  output code_t y
);
  localparam int ACC_W = CODE_W + SHIFT;
  localparam int TW    = $clog2(TICK + 1);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] tgt_sc;
  logic [ACC_W-1:0] gap;
  logic [ACC_W-1:0] stp;
  logic [ACC_W-1:0] acc_n;
  logic             up;
  logic [TW-1:0]    tcnt;

  always_comb begin
    tgt_sc = {tgt, {SHIFT{1'b0}}};
    up     = tgt_sc > acc;
    gap    = up ? (tgt_sc - acc) : (acc - tgt_sc);
    stp    = gap >> SHIFT;
    if (stp == '0 && gap != '0) stp = ACC_W'(1);
    acc_n  = up ? (acc + stp) : (acc - stp);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc  <= '0;
      tcnt <= '0;
    end else if (tcnt == TW'(TICK - 1)) begin
      tcnt <= '0;
      acc  <= acc_n;
    end else begin
      tcnt <= tcnt + TW'(1);
    end
  end

  assign y = acc[ACC_W-1:SHIFT];
endmodule

// File: rtl/pwmcap_top.sv
module pwmcap_top
  import pwmcap_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int TAU_US     = 80_000,
  parameter int FILT_SHIFT = 8,
  parameter int MIN_PWM_HZ = 15_000,
  parameter int SLEEP_US   = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwm_in,
  input  logic [1:0] min_duty_sel,
  input  logic       sleep_en,
  output logic [8:0] amp_cmd,
  output logic       standby,
  output logic       sleep
);
  localparam int CYC_US    = CLK_HZ / 1_000_000;
  localparam int TICK_RAW  = (CYC_US * TAU_US) >> FILT_SHIFT;
  localparam int TICK      = (TICK_RAW < 1) ? 1 : TICK_RAW;
  localparam int TIMEOUT   = 2 * CLK_HZ / MIN_PWM_HZ;
  localparam int CNT_W     = $clog2(TIMEOUT + 1);
  localparam int SLEEP_CYC = CYC_US * SLEEP_US;
  localparam int SLP_W     = $clog2(SLEEP_CYC + 1);

  logic             meas_clr;
  logic             div_go;
  logic [CNT_W-1:0] hi_w;
  logic [CNT_W-1:0] per_w;
  logic             frc_v;
  logic             frc_hi;
  logic             div_done;
  code_t            div_q;
  code_t            filt_y;

  logic [SLP_W-1:0] low_cnt;
  logic             sleep_q;
  logic             stby_q;
  code_t            duty_q;
  code_t            amp_q;

  logic             sleep_set;
  logic             new_v;
  code_t            new_code;
  logic             stby_d;
  code_t            duty_d;
  code_t            floor_v;
  code_t            amp_d;

  pwmcap_meas #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst(rst), .clr(meas_clr), .pwm_in(pwm_in),
    .div_go(div_go), .hi_o(hi_w), .per_o(per_w),
    .frc_v(frc_v), .frc_hi(frc_hi)
  );

  pwmcap_div #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .clr(meas_clr), .go(div_go),
    .num(hi_w), .den(per_w), .done(div_done), .q(div_q)
  );

  pwmcap_lpf #(.SHIFT(FILT_SHIFT), .TICK(TICK)) u_lpf (
    .clk(clk), .rst(rst), .clr(stby_d), .tgt(duty_q), .y(filt_y)
  );

  always_comb begin
    sleep_set = sleep_en && !pwm_in && !sleep_q &&
                (low_cnt >= SLP_W'(SLEEP_CYC - 1));
    meas_clr  = sleep_q || sleep_set;
    new_v     = div_done || frc_v;
    new_code  = frc_v ? (frc_hi ? code_t'(CODE_MAX) : '0) : div_q;
    stby_d    = stby_q;
    duty_d    = duty_q;
    if (sleep_set || sleep_q) begin
      stby_d = 1'b1;
      duty_d = '0;
    end else if (new_v) begin
      stby_d = new_code < code_t'(STBY_CODE);
      duty_d = new_code;
    end
    floor_v = floor_code(min_duty_sel);
    if (stby_d)             amp_d = '0;
    else if (filt_y > floor_v) amp_d = filt_y;
    else                    amp_d = floor_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      sleep_q <= 1'b0;
      stby_q  <= 1'b1;
      duty_q  <= '0;
      amp_q   <= '0;
    end else begin
      if (pwm_in) low_cnt <= '0;
      else if (low_cnt != SLP_W'(SLEEP_CYC)) low_cnt <= low_cnt + SLP_W'(1);
      if (sleep_set) sleep_q <= 1'b1;
      else if (sleep_q && pwm_in) sleep_q <= 1'b0;
      stby_q <= stby_d;
      duty_q <= duty_d;
      amp_q  <= amp_d;
    end
  end

  assign amp_cmd = amp_q;
  assign standby = stby_q;
  assign sleep   = sleep_q;
endmodule

// File: rtl/pwmcap_chk.sv
module pwmcap_chk
  import pwmcap_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       pwm_in,
  input logic [1:0] min_duty_sel,
  input logic       sleep_en,
  input logic [8:0] amp_cmd,
  input logic       standby,
  input logic       sleep,
  input logic [8:0] filt_tgt,
  input logic [8:0] filt_out
);
  // R5: standby forces a zero command
  p_stby_zero_r5: assert property (@(posedge clk) disable iff (rst)
    standby |-> amp_cmd == 9'd0);

  // R4: outside standby the command never sits below the selected floor
  p_floor_held_r4: assert property (@(posedge clk) disable iff (rst)
    !standby |-> amp_cmd >= floor_code($past(min_duty_sel)));

  // R6: sleep entry needs permission and a low input
  p_sleep_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep) |-> ($past(sleep_en) && !$past(pwm_in)));

  // R6: sleep is always accompanied by standby
  p_sleep_stby_r6: assert property (@(posedge clk) disable iff (rst)
    sleep |-> standby);

  // R7: a high input leaves sleep at the next edge
  p_wake_r7: assert property (@(posedge clk) disable iff (rst)
    (sleep && pwm_in) |=> !sleep);

  // R2: filter approaches from below without passing the target
  p_no_overshoot_up_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(filt_out) <= $past(filt_tgt) && $stable(filt_tgt)) |-> filt_out <= filt_tgt);

  // R2: filter approaches from above without passing the target
  p_no_overshoot_dn_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(filt_out) >= $past(filt_tgt) && $stable(filt_tgt)) |-> filt_out >= filt_tgt);
endmodule

bind pwmcap_top pwmcap_chk chk_i (
  .clk(clk), .rst(rst), .pwm_in(pwm_in), .min_duty_sel(min_duty_sel),
  .sleep_en(sleep_en), .amp_cmd(amp_cmd), .standby(standby), .sleep(sleep),
  .filt_tgt(duty_q), .filt_out(filt_y)
);

// File: tb/pwmcap_top_tb_top.sv
module pwmcap_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       slp_en = 1'b0;
  logic [8:0] amp;
  logic       stby;
  logic       slp;

  int checks = 0;
  int errors = 0;
  int drv_mode = 1;   // 0 pulse train, 1 constant low, 2 constant high
  int drv_per = 512;
  int drv_hi = 256;
  bit finished = 0;

  always #10 clk = ~clk;

  pwmcap_top #(.TAU_US(9), .FILT_SHIFT(6), .SLEEP_US(20)) dut_i (
    .clk(clk), .rst(rst), .pwm_in(pwm), .min_duty_sel(sel),
    .sleep_en(slp_en), .amp_cmd(amp), .standby(stby), .sleep(slp)
  );

  initial begin
    forever begin
      if (drv_mode == 0) begin
        pwm = 1'b1;
        repeat (drv_hi) @(negedge clk);
        pwm = 1'b0;
        repeat (drv_per - drv_hi) @(negedge clk);
      end else begin
        pwm = (drv_mode == 2);
        @(negedge clk);
      end
    end
  end

  function automatic int floor_of(input int s);
    case (s)
      1: return 26;
      2: return 51;
      3: return 67;
      default: return 0;
    endcase
  endfunction

  function automatic int code_of(input int p, input int h);
    longint c;
    c = (longint'(h) * 512) / p;
    return (c > 511) ? 511 : int'(c);
  endfunction

  function automatic int amp_of(input int c, input int s);
    if (c < 8) return 0;
    return (c > floor_of(s)) ? c : floor_of(s);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pwm(input int p, input int h);
    drv_per = p;
    drv_hi = h;
    drv_mode = 0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    int mx;
    seed_dummy = $urandom(32'd2024);
    wait_cyc(5);
    // R9 reset state
    check("R9 amp", int'(amp), 0);
    check("R9 standby", int'(stby), 1);
    check("R9 sleep", int'(slp), 0);
    rst = 1'b0;

    // R1 R4 basic duty with no floor
    set_pwm(512, 20);
    wait_cyc(10000);
    check("R1 code20", int'(amp), 20);
    check("R5 standby off", int'(stby), 0);

    // R3 R4 floor selection applies next edge
    for (int s = 1; s < 4; s++) begin
      sel = 2'(s);
      wait_cyc(2);
      check("R3 floor", int'(amp), floor_of(s));
    end

    // R4 duty above floor passes through
    set_pwm(512, 100);
    wait_cyc(10000);
    check("R4 above floor", int'(amp), 100);

    // R5 boundary: code 8 drives, code 7 is standby
    sel = 2'd0;
    set_pwm(512, 8);
    wait_cyc(10000);
    check("R5 code8 amp", int'(amp), 8);
    check("R5 code8 stby", int'(stby), 0);
    set_pwm(512, 7);
    wait_cyc(2000);
    check("R5 code7 amp", int'(amp), 0);
    check("R5 code7 stby", int'(stby), 1);

    // R2 ramp from standby: filtered, bounded, exact end value
    set_pwm(1000, 5);
    wait_cyc(3000);
    check("R5 low duty stby", int'(stby), 1);
    set_pwm(512, 300);
    while (stby) @(negedge clk);
    wait_cyc(200);
    check("R2 mid ramp", int'(amp > 0 && amp < 300), 1);
    mx = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (int'(amp) > mx) mx = int'(amp);
    end
    check("R2 no overshoot", mx, 300);
    check("R2 settled", int'(amp), 300);

    // R1 R3 R4 random periods and selections
    for (int k = 0; k < 4; k++) begin
      int p, h, s;
      p = 500 + int'($urandom % 2834);
      h = 1 + int'($urandom % (p - 1));
      s = int'($urandom % 4);
      sel = 2'(s);
      set_pwm(p, h);
      wait_cyc(12000);
      check("R1 random", int'(amp), amp_of(code_of(p, h), s));
    end

    // R6 R7 sleep entry and wake
    sel = 2'd0;
    slp_en = 1'b1;
    drv_mode = 2;
    wait_cyc(3400);
    drv_mode = 1;
    wait_cyc(900);
    check("R6 no sleep yet", int'(slp), 0);
    wait_cyc(200);
    check("R6 sleep", int'(slp), 1);
    check("R6 sleep stby", int'(stby), 1);
    check("R6 sleep amp", int'(amp), 0);
    set_pwm(512, 256);
    wait_cyc(3);
    check("R7 wake", int'(slp), 0);
    wait_cyc(200);
    check("R7 stby until period", int'(stby), 1);
    wait_cyc(10000);
    check("R7 restart", int'(amp), 256);

    // R6 R8 sleep disabled, timeouts on constant levels
    slp_en = 1'b0;
    drv_mode = 2;
    wait_cyc(3400);
    drv_mode = 1;
    wait_cyc(1100);
    check("R6 sleep disabled", int'(slp), 0);
    wait_cyc(6000);
    check("R8 low timeout stby", int'(stby), 1);
    check("R8 low timeout amp", int'(amp), 0);
    drv_mode = 2;
    wait_cyc(11000);
    check("R8 high timeout", int'(amp), 511);
    check("R8 high stby", int'(stby), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule